// File: doc/BRIEF.md
# Walsh Series Weighted Summer

This block forms one sample of a waveform built from square-wave basis functions. On every clock it receives the current level of 64 Walsh sequences, each one bit wide, where a 1 stands for +1 and a 0 for -1. It weights each sequence by its own signed 6-bit coefficient and adds the 64 weighted terms. The result is the digital value that an array of weighted current cells would produce at the same instant. Sequence 0 is the constant basis function, so coefficient slot 0 carries the offset of the series.

Coefficients come in as a full bank on a wide input and are captured by a load strobe. The captured bank is held in a staging register. It becomes the working bank only on the cycle that the sequence generator marks as the start of a period, so every period is synthesized with a single consistent bank. A fully pipelined adder tree produces one sum per clock. The sum is wide enough for every combination of inputs, and a valid flag shows when the pipeline holds real results after reset.

Top module: `walsh_sum`

## Requirements
- R1: `sum_out` equals the sum over i of (+c_i if `seq_bits[i]` is 1, -c_i if it is 0). Coefficient c_i is the two's-complement field `coef_bank[6*i+5:6*i]`, in the range -32..+31.
- R2: The sum for the inputs of a clock edge appears on `sum_out` 7 rising edges later (1 weighting stage + 6 tree levels). A new sample is accepted on every cycle.
- R3: A pulse on `coef_load` captures `coef_bank` into staging. The working bank changes only in a cycle where `period_start` is high and a staged bank is pending. The sample presented in that same cycle already uses the new bank.
- R4: A `coef_load` that is not followed by `period_start` leaves the output computed with the previous working bank.
- R5: When several loads arrive before one `period_start`, the last loaded bank is the one that takes effect.
- R6: When `coef_load` and `period_start` are high in the same cycle, the swap uses the bank staged earlier. The newly loaded bank takes effect at the next `period_start`.
- R7: `sum_out` is 13-bit signed and never overflows. All coefficients -32 with all sequences 0 gives +2048. All -32 with all sequences 1 gives -2048. All +31 with all sequences 1 gives +1984.
- R8: A synchronous active-high reset clears the staging bank, the working bank, the pending flag and the pipeline. During reset `sum_out` is 0 and `sum_valid` is 0. After reset release `sum_valid` rises on exactly the 7th rising edge and stays high.
- R9: With only slot 0 non-zero, the output is +c_0 when `seq_bits[0]` is 1 and -c_0 when it is 0, whatever the other sequence bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequence clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_bits | input | 64 | Current level of each Walsh sequence, 1 = +1, 0 = -1 |
| period_start | input | 1 | First cycle of a sequence period; swaps in a pending bank |
| coef_load | input | 1 | Captures `coef_bank` into staging |
| coef_bank | input | 384 | 64 signed 6-bit coefficients, slot i at bits 6i+5..6i |
| sum_out | output | 13 | Registered signed weighted sum |
| sum_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
The assertions check on every cycle that:
- the working bank holds its value outside a period start with a pending bank;
- a swap installs exactly the previously staged bank;
- a valid sum always stays inside ±2048;
- the valid flag follows the fill count after reset.

The arithmetic cannot be shown by a property and is left to the bench scenarios. These cover the weighted sum against a behavioural sum for random banks, the seven-cycle latency under a streaming input, and the ordering of loads and period starts. They also cover the extreme sums and the clearing of the banks by reset.

// File: rtl/walsh_sum_pkg.sv
package walsh_sum_pkg;

  // Sum width that holds NSEQ terms of magnitude up to 2^(CW-1) without overflow.
  function automatic int sum_width(input int nseq, input int cw);
    return cw + $clog2(nseq) + 1;
  endfunction

  // Cycles from input sampling to a registered sum.
  function automatic int pipe_latency(input int nseq);
    return $clog2(nseq) + 1;
  endfunction

endpackage

// File: rtl/walsh_coef_bank.sv
module walsh_coef_bank #(
  parameter int NSEQ = 64,
  parameter int CW   = 6,
  localparam int BW  = NSEQ * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coef_load,
  input  logic [BW-1:0] coef_in,
  input  logic          period_start,
  output logic [BW-1:0] bank_eff,
  output logic [BW-1:0] act_q,
  output logic [BW-1:0] stg_q,
  output logic          pend_q
);

  logic swap;
  assign swap = period_start & pend_q;

  // The sample taken on a swapping cycle already sees the staged bank.
  assign bank_eff = swap ? stg_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (coef_load) stg_q <= coef_in;
      if (swap)      act_q <= stg_q;
      pend_q <= coef_load | (pend_q & ~period_start);
    end
  end

endmodule

// File: rtl/walsh_term_stage.sv
module walsh_term_stage #(
  parameter int NSEQ = 64,
  parameter int CW   = 6,
  localparam int TW  = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSEQ-1:0]      seq,
  input  logic [NSEQ*CW-1:0]   bank,
  output logic [NSEQ*TW-1:0]   terms
);

  for (genvar i = 0; i < NSEQ; i++) begin : g_term
    logic signed [TW-1:0] ext;
    assign ext = {bank[i*CW+CW-1], bank[i*CW +: CW]};
    always_ff @(posedge clk) begin
      if (rst) terms[i*TW +: TW] <= '0;
      else     terms[i*TW +: TW] <= seq[i] ? ext : -ext;
    end
  end

endmodule

// File: rtl/walsh_add_tree.sv
module walsh_add_tree #(
  parameter int NSEQ = 64,
  parameter int TW   = 7,
  parameter int SW   = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSEQ*TW-1:0]    leaves,
  output logic signed [SW-1:0]  sum_q
);

  // Heap layout: node 1 is the root, nodes NSEQ..2*NSEQ-1 are the leaves.
  logic signed [SW-1:0] nd    [1:NSEQ-1];
  logic signed [SW-1:0] all_n [1:2*NSEQ-1];

  always_comb begin
    for (int k = 1; k < 2*NSEQ; k++) begin
      if (k < NSEQ) all_n[k] = nd[k];
      else all_n[k] = {{(SW-TW){leaves[(k-NSEQ)*TW+TW-1]}}, leaves[(k-NSEQ)*TW +: TW]};
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k < NSEQ; k++) begin
      if (rst) nd[k] <= '0;
      else     nd[k] <= all_n[2*k] + all_n[2*k+1];
    end
  end

  assign sum_q = nd[1];

endmodule

// File: rtl/walsh_sum.sv
module walsh_sum
  import walsh_sum_pkg::*;
#(
  parameter int NSEQ = 64,
  parameter int CW   = 6,
  localparam int SW  = sum_width(NSEQ, CW),
  localparam int LAT = pipe_latency(NSEQ),
  localparam int TW  = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSEQ-1:0]      seq_bits,
  input  logic                 period_start,
  input  logic                 coef_load,
  input  logic [NSEQ*CW-1:0]   coef_bank,
  output logic signed [SW-1:0] sum_out,
  output logic                 sum_valid
);

  logic [NSEQ*CW-1:0] bank_eff, act_bank, stg_bank;
  logic               bank_pend;
  logic [NSEQ*TW-1:0] terms;
  logic [LAT-1:0]     vld_sr;

  walsh_coef_bank #(.NSEQ(NSEQ), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_bank),
    .period_start(period_start), .bank_eff(bank_eff), .act_q(act_bank),
    .stg_q(stg_bank), .pend_q(bank_pend)
  );

  walsh_term_stage #(.NSEQ(NSEQ), .CW(CW)) u_terms (
    .clk(clk), .rst(rst), .seq(seq_bits), .bank(bank_eff), .terms(terms)
  );

  walsh_add_tree #(.NSEQ(NSEQ), .TW(TW), .SW(SW)) u_tree (
    .clk(clk), .rst(rst), .leaves(terms), .sum_q(sum_out)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_sr <= '0;
    else     vld_sr <= {vld_sr[LAT-2:0], 1'b1};
  end

  assign sum_valid = vld_sr[LAT-1];

endmodule

// File: rtl/walsh_sum_chk.sv
module walsh_sum_chk #(
  parameter int NSEQ = 64,
  parameter int CW   = 6,
  parameter int SW   = 13,
  parameter int LAT  = 7,
  localparam int BW  = NSEQ * CW,
  localparam int LIM = NSEQ * (1 << (CW - 1)),
  localparam int CNW = $clog2(LAT + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 period_start,
  input logic                 pend,
  input logic [BW-1:0]        act,
  input logic [BW-1:0]        stg,
  input logic signed [SW-1:0] sum_out,
  input logic                 sum_valid
);

  logic [CNW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst)                      fill_cnt <= '0;
    else if (fill_cnt != CNW'(LAT)) fill_cnt <= fill_cnt + 1'b1;
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(period_start && pend) |=> $stable(act)); // R3

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
    (period_start && pend) |=> (act == $past(stg))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (int'(sum_out) <= LIM && int'(sum_out) >= -LIM)); // R7

  AST_VALID_FILL: assert property (@(posedge clk) disable iff (rst)
    sum_valid == (fill_cnt == CNW'(LAT))); // R8

endmodule

bind walsh_sum walsh_sum_chk #(.NSEQ(NSEQ), .CW(CW), .SW(SW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .period_start(period_start), .pend(bank_pend),
  .act(act_bank), .stg(stg_bank), .sum_out(sum_out), .sum_valid(sum_valid)
);

// File: tb/walsh_sum_tb.sv
`timescale 1ns/1ps
module walsh_sum_tb;

  localparam int NSEQ = 64;
  localparam int CW   = 6;
  localparam int BW   = NSEQ * CW;
  localparam int NTAB = 6;
  localparam real CLK_P = 20.0;

  localparam logic [63:0] SEQ_TAB [0:NTAB-1] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA,
    64'h0F0F_0F0F_F0F0_F0F0, 64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0001};
  localparam int unsigned SEED_TAB [0:NTAB-1] = '{32'd7, 32'd1001, 32'd4242,
    32'd65537, 32'd99, 32'd31337};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSEQ-1:0] seq_bits = '0;
  logic period_start = 1'b0;
  logic coef_load = 1'b0;
  logic [BW-1:0] coef_bank = '0;
  logic signed [12:0] sum_out;
  logic sum_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  walsh_sum u_dut (
    .clk(clk), .rst(rst), .seq_bits(seq_bits), .period_start(period_start),
    .coef_load(coef_load), .coef_bank(coef_bank), .sum_out(sum_out), .sum_valid(sum_valid)
  );

  function automatic logic [BW-1:0] mk_bank(input int unsigned seed);
    logic [BW-1:0] b;
    int unsigned s = seed;
    for (int i = 0; i < NSEQ; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      b[i*CW +: CW] = s[21:16];
    end
    return b;
  endfunction

  function automatic int ref_sum(input logic [BW-1:0] b, input logic [NSEQ-1:0] s);
    int acc = 0;
    for (int i = 0; i < NSEQ; i++) begin
      int c = int'($signed(b[i*CW +: CW]));
      acc += s[i] ? c : -c;
    end
    return acc;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_sum(input string tag, input int exp);
    n_run++;
    if (int'(sum_out) != exp) begin
      n_fail++;
      $display("FAIL %s: sum_out actual %0d expected %0d", tag, int'(sum_out), exp);
    end
  endtask

  task automatic chk_valid(input string tag, input logic exp);
    n_run++;
    if (sum_valid !== exp) begin
      n_fail++;
      $display("FAIL %s: sum_valid actual %0b expected %0b", tag, sum_valid, exp);
    end
  endtask

  // Load a bank, start a period with seq, and check after the pipeline latency.
  task automatic swap_run(input logic [BW-1:0] b, input logic [NSEQ-1:0] s, input string tag);
    @(negedge clk); coef_load = 1'b1; coef_bank = b;
    @(negedge clk); coef_load = 1'b0; period_start = 1'b1; seq_bits = s;
    @(negedge clk); period_start = 1'b0;
    tick(6);
    chk_sum(tag, ref_sum(b, s));
  endtask

  initial begin
    logic [BW-1:0] bank_a, bank_b, bank_c;
    logic [NSEQ-1:0] sq [0:19];

    // R8: reset state and valid fill timing
    tick(3);
    chk_sum("R8 reset sum", 0);
    chk_valid("R8 reset valid", 1'b0);
    rst = 1'b0;
    tick(6);
    chk_valid("R8 valid before fill", 1'b0);
    tick(1);
    chk_valid("R8 valid after fill", 1'b1);
    chk_sum("R8 zero bank", 0);

    // R1 / R3: table of random banks and sequence patterns
    for (int i = 0; i < NTAB; i++)
      swap_run(mk_bank(SEED_TAB[i]), SEQ_TAB[i], "R1 R3 table");

    // R2: streaming, one sample per cycle, 7-cycle latency
    bank_a = mk_bank(32'd555);
    swap_run(bank_a, 64'h0, "R2 preload");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k >= 7) chk_sum("R2 stream", ref_sum(bank_a, sq[k-7]));
      sq[k] = {$urandom, $urandom};
      seq_bits = sq[k];
    end

    // R4: load without period start leaves the old bank in use
    bank_b = mk_bank(32'd777);
    @(negedge clk); coef_load = 1'b1; coef_bank = bank_b; seq_bits = 64'h00FF_00FF_1357_9BDF;
    @(negedge clk); coef_load = 1'b0;
    tick(7);
    chk_sum("R4 no swap", ref_sum(bank_a, 64'h00FF_00FF_1357_9BDF));

    // R5: last of several loads wins
    bank_b = mk_bank(32'd888);
    bank_c = mk_bank(32'd999);
    @(negedge clk); coef_load = 1'b1; coef_bank = bank_b;
    @(negedge clk); coef_bank = bank_c;
    @(negedge clk); coef_load = 1'b0; period_start = 1'b1; seq_bits = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk); period_start = 1'b0;
    tick(6);
    chk_sum("R5 last load", ref_sum(bank_c, 64'hDEAD_BEEF_0123_4567));

    // R6: load and start together swap the earlier staged bank
    bank_a = mk_bank(32'd1111);
    bank_b = mk_bank(32'd2222);
    @(negedge clk); coef_load = 1'b1; coef_bank = bank_a;
    @(negedge clk); coef_bank = bank_b; period_start = 1'b1; seq_bits = 64'h5555_0000_FFFF_3333;
    @(negedge clk); coef_load = 1'b0; period_start = 1'b0;
    tick(6);
    chk_sum("R6 earlier staged", ref_sum(bank_a, 64'h5555_0000_FFFF_3333));
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    tick(6);
    chk_sum("R6 next start", ref_sum(bank_b, 64'h5555_0000_FFFF_3333));

    // R7: extremes of the range
    swap_run({NSEQ{6'h20}}, 64'h0, "R7 max positive");
    chk_sum("R7 max positive const", 2048);
    swap_run({NSEQ{6'h20}}, {NSEQ{1'b1}}, "R7 max negative");
    chk_sum("R7 max negative const", -2048);
    swap_run({NSEQ{6'h1F}}, {NSEQ{1'b1}}, "R7 all plus31");
    chk_sum("R7 all plus31 const", 1984);

    // R9: offset slot 0 only
    bank_a = '0;
    bank_a[5:0] = 6'b101111; // -17
    swap_run(bank_a, 64'hFFFF_0000_1234_5671, "R9 bit0 high");
    chk_sum("R9 bit0 high const", -17);
    swap_run(bank_a, 64'hFFFF_0000_1234_5670, "R9 bit0 low");
    chk_sum("R9 bit0 low const", 17);

    // R8: reset mid-run clears banks and pending state
    @(negedge clk); coef_load = 1'b1; coef_bank = mk_bank(32'd3);
    @(negedge clk); coef_load = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk_sum("R8 mid reset sum", 0);
    chk_valid("R8 mid reset valid", 1'b0);
    rst = 1'b0; seq_bits = 64'hFFFF_FFFF_0000_0000;
    tick(1); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    tick(7);
    chk_sum("R8 banks cleared", 0);
    chk_valid("R8 valid refilled", 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule